// File: doc/BRIEF.md
# Soft-Start Reference Ramp Controller

This block drives the digital reference code of a switching regulator's control loop from zero up to a programmed setpoint code during start-up. The ramp advances one step on each tick of a soft-start clock, divided down from the system clock. A 4-bit strap index selects the soft-start clock rate and a light-load pulse-skipping enable. The number of ramp steps comes from the setpoint range, so higher setpoints take longer to ramp.

The reference is compared with the digitized feedback code. Switching is held off until the reference rises above a pre-charged output level, so a pre-biased output is never pulled down. A fault pulse drops the reference to zero and opens a restart window of fixed length in soft-start ticks. When the window closes the ramp runs again. Dropping enable returns everything to rest.

Top module: `ss_ramp_ctrl`

## Requirements
- R1: The strap index is captured on the cycle enable first rises. pfm_en_o reflects the captured value, and later strap changes have no effect until enable is dropped and raised again.
- R2: Strap index decoding, with divider select s giving a tick period of DIV_BASE<<s system cycles:
  - index 0 gives PFM off, s=1;
  - indices 1..4 give PFM on, s=0..3;
  - indices 5..8 give PFM off, s=0..3.
- R3: The ramp takes T ticks, counting from its first tick to the one that raises done_o. T is TICKS_LO for a setpoint ≤ BAND_LO_MAX, TICKS_MID for a setpoint ≤ BAND_MID_MAX, and TICKS_HI above that.
- R4: After the k-th ramp tick, ref_o = min(sp, floor(k·step / 2^FRAC)), where step = ceil(sp·2^FRAC / T). ref_o never decreases during a ramp and never exceeds the setpoint.
- R5: done_o rises on the tick where ref_o reaches the setpoint. From then on ref_o holds the setpoint.
- R6: sw_en_o rises in the same cycle that ref_o first exceeds feedback_i, or when done_o rises, whichever comes first. Once high it stays high until a fault or disable. With feedback at or above the setpoint it rises only with done_o.
- R7: A fault pulse while ramping or done takes effect on the next cycle:
  - ref_o, sw_en_o and done_o clear;
  - hiccup_o is high for exactly HICCUP_TICKS·(DIV_BASE<<s) cycles;
  - a fresh ramp then starts.
  Fault pulses while the step is being computed, or during the restart window, are ignored.
- R8: With enable low, or in reset, every output is zero one cycle later.
- R9: Strap indices 9..15 decode like index 0: PFM off, s=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Start-up enable; low clears all state |
| strap_i | input | 4 | Strap selection index |
| setpoint_i | input | SP_W | Target reference code, captured at enable |
| feedback_i | input | SP_W | Digitized output feedback code |
| fault_i | input | 1 | Fault pulse, starts a restart window |
| ref_o | output | SP_W | Ramping reference code |
| sw_en_o | output | 1 | Switching permitted |
| done_o | output | 1 | Ramp complete |
| pfm_en_o | output | 1 | Light-load pulse-skipping enable |
| hiccup_o | output | 1 | Restart window active |

## Verification
The bench sweeps all sixteen strap indices against setpoints in each of the three bands. For every pair it tries three feedback levels: zero, half the setpoint and the full setpoint.

- The spacing between reference updates separates the four clock rates.
- The number of updates separates the three step counts.
- The three feedback levels separate immediate switching, mid-ramp switching and switching held until the ramp completes.

Mid-ramp faults, faults after completion, faults during step computation and faults inside the restart window separate the accepted fault cases from the ignored ones. The length of the window confirms that it scales with the selected clock.

// File: rtl/ss_pkg.sv
package ss_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV,
    ST_RAMP,
    ST_HOLD,
    ST_HICCUP
  } ss_state_t;

  typedef struct packed {
    logic       pfm;
    logic [1:0] sel;
  } strap_cfg_t;

  // Index 0 and unused indices fall back to PFM off at divider select 1.
  function automatic strap_cfg_t decode_strap(input logic [3:0] idx);
    strap_cfg_t c;
    c.pfm = 1'b0;
    c.sel = 2'd1;
    if (idx >= 4'd1 && idx <= 4'd4) begin
      c.pfm = 1'b1;
      c.sel = 2'(idx - 4'd1);
    end else if (idx >= 4'd5 && idx <= 4'd8) begin
      c.pfm = 1'b0;
      c.sel = 2'(idx - 4'd5);
    end
    return c;
  endfunction

endpackage

// File: rtl/ss_cfg_decode.sv
module ss_cfg_decode
  import ss_pkg::*;
#(
  parameter int SP_W         = 10,
  parameter int T_W          = 12,
  parameter int TICKS_LO     = 900,
  parameter int TICKS_MID    = 1800,
  parameter int TICKS_HI     = 3600,
  parameter int BAND_LO_MAX  = 280,
  parameter int BAND_MID_MAX = 560
) (
  input  logic [3:0]      strap_i,
  input  logic [SP_W-1:0] setpoint_i,
  output logic            pfm_o,
  output logic [1:0]      sel_o,
  output logic [T_W-1:0]  ticks_o
);
  localparam logic [SP_W-1:0] LIM_LO  = SP_W'(BAND_LO_MAX);
  localparam logic [SP_W-1:0] LIM_MID = SP_W'(BAND_MID_MAX);

  strap_cfg_t cfg;

  always_comb begin
    cfg   = decode_strap(strap_i);
    pfm_o = cfg.pfm;
    sel_o = cfg.sel;
    if (setpoint_i <= LIM_LO)       ticks_o = T_W'(TICKS_LO);
    else if (setpoint_i <= LIM_MID) ticks_o = T_W'(TICKS_MID);
    else                            ticks_o = T_W'(TICKS_HI);
  end
endmodule

// File: rtl/ss_tick_gen.sv
module ss_tick_gen #(
  parameter int DIV_BASE = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int CW = $clog2(DIV_BASE * 8) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = (CW'(DIV_BASE) << sel_i) - CW'(1);
  assign tick_o = run_i && !clr_i && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || !run_i || clr_i) cnt_q <= '0;
    else if (tick_o)            cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/ss_step_div.sv
module ss_step_div #(
  parameter int NUM_W = 34,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] q_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  assign trial  = {rem_q, q_q[NUM_W-1]};
  assign diff   = trial - {1'b0, den_q};
  assign ge     = trial >= {1'b0, den_q};
  assign quot_o = q_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0; den_q <= '0; q_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        den_q  <= den_i;
        q_q    <= num_i;
        cnt_q  <= CW'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        q_q   <= {q_q[NUM_W-2:0], ge};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ss_ramp_ctrl.sv
module ss_ramp_ctrl
  import ss_pkg::*;
#(
  parameter int SP_W         = 10,
  parameter int FRAC         = 24,
  parameter int DIV_BASE     = 8,
  parameter int TICKS_LO     = 900,
  parameter int TICKS_MID    = 1800,
  parameter int TICKS_HI     = 3600,
  parameter int HICCUP_TICKS = 25200,
  parameter int BAND_LO_MAX  = 280,
  parameter int BAND_MID_MAX = 560
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  input  logic [3:0]      strap_i,
  input  logic [SP_W-1:0] setpoint_i,
  input  logic [SP_W-1:0] feedback_i,
  input  logic            fault_i,
  output logic [SP_W-1:0] ref_o,
  output logic            sw_en_o,
  output logic            done_o,
  output logic            pfm_en_o,
  output logic            hiccup_o
);
  localparam int T_W   = $clog2(TICKS_HI + 1);
  localparam int H_W   = $clog2(HICCUP_TICKS + 1);
  localparam int NUM_W = SP_W + FRAC;
  localparam int ACC_W = NUM_W + 1;

  ss_state_t        st_q, st_d;
  logic [SP_W-1:0]  sp_q, ref_d;
  logic [1:0]       sel_q, dec_sel;
  logic             dec_pfm, done_d, sw_d, hic_d, latch, div_start, div_done;
  logic [T_W-1:0]   dec_ticks;
  logic [NUM_W-1:0] step_q, quot;
  logic [ACC_W-1:0] acc_q, acc_d, acc_sum, sp_full;
  logic [H_W-1:0]   hcnt_q, hcnt_d;
  logic             tick, tick_run, fault_take;

  ss_cfg_decode #(
    .SP_W(SP_W), .T_W(T_W), .TICKS_LO(TICKS_LO), .TICKS_MID(TICKS_MID),
    .TICKS_HI(TICKS_HI), .BAND_LO_MAX(BAND_LO_MAX), .BAND_MID_MAX(BAND_MID_MAX)
  ) u_dec (
    .strap_i(strap_i), .setpoint_i(setpoint_i),
    .pfm_o(dec_pfm), .sel_o(dec_sel), .ticks_o(dec_ticks)
  );

  // Ceiling division so the clamp is reached on exactly the T-th tick.
  ss_step_div #(.NUM_W(NUM_W), .DEN_W(T_W)) u_div (
    .clk(clk), .rst(rst || !en_i), .start_i(div_start),
    .num_i({setpoint_i, {FRAC{1'b0}}} + NUM_W'(dec_ticks - T_W'(1))),
    .den_i(dec_ticks), .done_o(div_done), .quot_o(quot)
  );

  assign tick_run   = (st_q == ST_RAMP) || (st_q == ST_HICCUP);
  assign fault_take = fault_i && ((st_q == ST_RAMP) || (st_q == ST_HOLD));

  ss_tick_gen #(.DIV_BASE(DIV_BASE)) u_tick (
    .clk(clk), .rst(rst), .run_i(tick_run), .clr_i(fault_take),
    .sel_i(sel_q), .tick_o(tick)
  );

  assign acc_sum = acc_q + {1'b0, step_q};
  assign sp_full = {1'b0, sp_q, {FRAC{1'b0}}};

  always_comb begin
    st_d      = st_q;
    acc_d     = acc_q;
    ref_d     = ref_o;
    done_d    = done_o;
    hic_d     = hiccup_o;
    hcnt_d    = hcnt_q;
    latch     = 1'b0;
    div_start = 1'b0;
    case (st_q)
      ST_IDLE: begin
        latch     = 1'b1;
        div_start = 1'b1;
        st_d      = ST_DIV;
      end
      ST_DIV: if (div_done) st_d = ST_RAMP;
      ST_RAMP: if (tick) begin
        if (acc_sum >= sp_full) begin
          acc_d  = sp_full;
          ref_d  = sp_q;
          done_d = 1'b1;
          st_d   = ST_HOLD;
        end else begin
          acc_d = acc_sum;
          ref_d = acc_sum[FRAC +: SP_W];
        end
      end
      ST_HICCUP: if (tick) begin
        if (hcnt_q == H_W'(HICCUP_TICKS - 1)) begin
          hcnt_d = '0;
          hic_d  = 1'b0;
          st_d   = ST_RAMP;
        end else begin
          hcnt_d = hcnt_q + H_W'(1);
        end
      end
      default: ;
    endcase
    if (fault_take) begin
      st_d   = ST_HICCUP;
      acc_d  = '0;
      ref_d  = '0;
      done_d = 1'b0;
      hic_d  = 1'b1;
      hcnt_d = '0;
      sw_d   = 1'b0;
    end else begin
      sw_d = sw_en_o || (ref_d > feedback_i) || done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      st_q <= ST_IDLE; sp_q <= '0; sel_q <= '0; step_q <= '0;
      acc_q <= '0; hcnt_q <= '0; ref_o <= '0; sw_en_o <= 1'b0;
      done_o <= 1'b0; pfm_en_o <= 1'b0; hiccup_o <= 1'b0;
    end else begin
      st_q     <= st_d;
      acc_q    <= acc_d;
      hcnt_q   <= hcnt_d;
      ref_o    <= ref_d;
      done_o   <= done_d;
      sw_en_o  <= sw_d;
      hiccup_o <= hic_d;
      if (latch) begin
        sp_q     <= setpoint_i;
        sel_q    <= dec_sel;
        pfm_en_o <= dec_pfm;
      end
      if (div_done) step_q <= quot;
    end
  end
endmodule

// File: rtl/ss_ramp_ctrl_chk.sv
module ss_ramp_ctrl_chk #(
  parameter int SP_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            en_i,
  input logic            fault_i,
  input logic [SP_W-1:0] feedback_i,
  input logic [SP_W-1:0] ref_o,
  input logic            sw_en_o,
  input logic            done_o,
  input logic            pfm_en_o,
  input logic            hiccup_o,
  input logic [SP_W-1:0] sp_q
);
  AST_PFM_HELD: assert property (@(posedge clk) disable iff (rst)
    (en_i && $past(en_i) && $past(en_i, 2)) |-> $stable(pfm_en_o)); // R1

  AST_REF_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    (en_i && $past(en_i) && !hiccup_o) |-> (ref_o >= $past(ref_o))); // R4

  AST_REF_NOT_ABOVE_SP: assert property (@(posedge clk) disable iff (rst)
    ref_o <= sp_q); // R4

  AST_DONE_AT_SETPOINT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ref_o == sp_q)); // R5

  AST_SWITCH_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_en_o) |-> ((ref_o > $past(feedback_i)) || done_o)); // R6

  AST_FAULT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (fault_i && done_o && en_i) |=> (hiccup_o && ref_o == '0 && !sw_en_o)); // R7

  AST_HICCUP_QUIET: assert property (@(posedge clk) disable iff (rst)
    hiccup_o |-> (ref_o == '0 && !sw_en_o && !done_o)); // R7

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !$past(en_i) |-> (ref_o == '0 && !sw_en_o && !done_o && !pfm_en_o && !hiccup_o)); // R8
endmodule

bind ss_ramp_ctrl ss_ramp_ctrl_chk #(.SP_W(SP_W)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .fault_i(fault_i), .feedback_i(feedback_i),
  .ref_o(ref_o), .sw_en_o(sw_en_o), .done_o(done_o), .pfm_en_o(pfm_en_o),
  .hiccup_o(hiccup_o), .sp_q(sp_q)
);

// File: tb/tb_ss_ramp_ctrl.sv
module tb_ss_ramp_ctrl;
  localparam int SP_W = 10;
  localparam int FRAC = 24;
  localparam int BASE = 1;
  localparam int TL = 4, TM = 8, TH = 16, HT = 5;
  localparam int B1 = 280, B2 = 560;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, fault = 1'b0;
  logic [3:0] strap = '0;
  logic [SP_W-1:0] sp = '0, fb = '0;
  logic [SP_W-1:0] ref_o;
  logic sw_en_o, done_o, pfm_en_o, hiccup_o;

  int vectors = 0, miscompares = 0, cycles = 0;

  always #2.5 clk = ~clk;

  ss_ramp_ctrl #(
    .SP_W(SP_W), .FRAC(FRAC), .DIV_BASE(BASE), .TICKS_LO(TL), .TICKS_MID(TM),
    .TICKS_HI(TH), .HICCUP_TICKS(HT), .BAND_LO_MAX(B1), .BAND_MID_MAX(B2)
  ) dut (
    .clk(clk), .rst(rst), .en_i(en), .strap_i(strap), .setpoint_i(sp),
    .feedback_i(fb), .fault_i(fault), .ref_o(ref_o), .sw_en_o(sw_en_o),
    .done_o(done_o), .pfm_en_o(pfm_en_o), .hiccup_o(hiccup_o)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_sel(input int s);
    if (s >= 1 && s <= 4) return s - 1;
    if (s >= 5 && s <= 8) return s - 5;
    return 1;
  endfunction

  function automatic bit exp_pfm(input int s);
    return (s >= 1 && s <= 4);
  endfunction

  function automatic int exp_ticks(input int v);
    if (v <= B1) return TL;
    if (v <= B2) return TM;
    return TH;
  endfunction

  // Follows one ramp from its start to done; checks R2..R6 and the absence of hiccup.
  task automatic watch_ramp(input int v, input int f, input int n, input string ctx);
    int t = exp_ticks(v);
    longint step = ((longint'(v) << FRAC) + t - 1) / t;
    int k = 0, gap = 0, guard = 0;
    int last = int'(ref_o);
    bit swexp = 1'b0;
    while (1) begin
      @(negedge clk);
      guard++;
      gap++;
      if (int'(ref_o) != last) begin
        longint e;
        k++;
        if (k > 1) check(gap == n, "R2", {ctx, " tick spacing"}, gap, n);
        e = (longint'(k) * step) >>> FRAC;
        if (e > v) e = v;
        check(longint'(ref_o) == e, "R4", {ctx, " ref step value"}, ref_o, e);
        gap = 0;
        last = int'(ref_o);
      end
      swexp = swexp || (int'(ref_o) > f) || done_o;
      check(sw_en_o == swexp, "R6", {ctx, " switching enable"}, sw_en_o, swexp);
      check(hiccup_o == 1'b0, "R7", {ctx, " no hiccup during ramp"}, hiccup_o, 0);
      if (done_o || guard > 3000) break;
    end
    check(k == t, "R3", {ctx, " ramp tick count"}, k, t);
    check(done_o == 1'b1, "R5", {ctx, " done raised"}, done_o, 1);
    check(int'(ref_o) == v, "R5", {ctx, " final ref"}, ref_o, v);
  endtask

  task automatic check_idle(input string ctx);
    check(ref_o == '0 && !sw_en_o && !done_o && !pfm_en_o && !hiccup_o, "R8",
          {ctx, " outputs cleared"}, {ref_o, sw_en_o, done_o, pfm_en_o, hiccup_o}, 0);
  endtask

  initial begin
    int spv[3] = '{40, 300, 700};
    repeat (4) @(negedge clk);
    check_idle("reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("after reset, enable low");

    // Sweep straps x setpoint bands x feedback levels.
    for (int s = 0; s < 16; s++) begin
      for (int i = 0; i < 3; i++) begin
        for (int j = 0; j < 3; j++) begin
          int v = spv[i];
          int f = (j == 0) ? 0 : (j == 1) ? v / 2 : v;
          strap = 4'(s); sp = SP_W'(v); fb = SP_W'(f); en = 1'b1;
          @(negedge clk);
          strap = ~4'(s);   // change after capture: must have no effect (R1)
          watch_ramp(v, f, BASE << exp_sel(s), $sformatf("strap %0d sp %0d fb %0d", s, v, f));
          if (s >= 9) check(pfm_en_o == exp_pfm(s), "R9", "unused strap pfm", pfm_en_o, exp_pfm(s));
          else        check(pfm_en_o == exp_pfm(s), "R1", "strap pfm held", pfm_en_o, exp_pfm(s));
          en = 1'b0;
          @(negedge clk);
          check_idle("disable after ramp");
        end
      end
    end

    // Fault during step computation is ignored (R7).
    strap = 4'd2; sp = 10'd700; fb = '0; en = 1'b1;
    @(negedge clk);
    fault = 1'b1;
    @(negedge clk);
    fault = 1'b0;
    check(hiccup_o == 1'b0, "R7", "fault during step calc ignored", hiccup_o, 0);
    watch_ramp(700, 0, 2, "after ignored fault");

    // Fault after done, then a fault inside the restart window.
    fault = 1'b1;
    @(negedge clk);
    fault = 1'b0;
    check(hiccup_o && ref_o == '0 && !sw_en_o && !done_o, "R7", "fault after done",
          {hiccup_o, ref_o, sw_en_o, done_o}, {1'b1, 13'd0});
    begin
      int cnt = 1;
      while (1) begin
        @(negedge clk);
        if (cnt == 3) fault = 1'b1;
        else fault = 1'b0;
        if (!hiccup_o || cnt > 500) break;
        cnt++;
      end
      fault = 1'b0;
      check(cnt == HT * 2, "R7", "hiccup window length", cnt, HT * 2);
    end
    watch_ramp(700, 0, 2, "restart after hiccup");
    en = 1'b0;
    @(negedge clk);

    // Fault mid-ramp at the slowest clock, then disable inside the window.
    strap = 4'd8; sp = 10'd700; fb = 10'd100; en = 1'b1;
    while (ref_o < 10'd200) @(negedge clk);
    fault = 1'b1;
    @(negedge clk);
    fault = 1'b0;
    check(hiccup_o && ref_o == '0 && !sw_en_o, "R7", "fault mid-ramp",
          {hiccup_o, ref_o, sw_en_o}, {1'b1, 11'd0});
    begin
      int cnt = 1;
      while (hiccup_o && cnt < 500) begin
        @(negedge clk);
        if (hiccup_o) cnt++;
      end
      check(cnt == HT * 8, "R7", "hiccup window at slowest clock", cnt, HT * 8);
    end
    watch_ramp(700, 100, 8, "restart slow clock");
    fault = 1'b1;
    @(negedge clk);
    fault = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check_idle("disable during hiccup");

    summary();
    $finish;
  end
endmodule